// File: doc/BRIEF.md
# Elastic Fork-Join Datapath

Each accepted input word is copied into two internally pipelined branches whose latencies may differ. The branch with more register stages (F by default) runs straight to a join stage. The branch with fewer stages (G by default) runs into a small first-in first-out buffer. The join stage combines the two results by adding them modulo 2^DATA_W, which gives H(F(x), G(x)). Both branches are pure delay pipelines, so every output equals twice its input, truncated to DATA_W bits.

Each pipeline stage carries its own valid flag. A stage advances whenever the stage after it can take its content. As a result, bubbles collapse and a stall spreads backwards only as far as needed. Results are paired because both branches see the same input sequence and drain in the same order, not because their register counts match. If the buffer is too shallow for the latency gap, the short branch stalls and throughput drops, but the output values stay correct.

The input and the output are valid/ready streams. A word moves across an interface on any clock edge where both valid and ready are high.

Top module: `elastic_fork_join`

## Requirements
- R1: The output stream, in order, holds exactly one word for each accepted input, and each word equals (x + x) mod 2^DATA_W for that same input x. Words from different inputs are never combined.
- R2: in_ready is high only when the first stage of both branches can take a word. An input offered while in_ready is low is not taken and never appears at the output.
- R3: The buffer is never written while full and never read while empty.
- R4: While out_valid is high and out_ready is low, out_valid stays high and out_data does not change on the next cycle.
- R5: With the block empty, out_ready high and LAT_G < LAT_F, an input accepted on one rising edge gives out_valid high with its result in the cycle that starts LAT_F−1 rising edges later, and out_valid stays low before that.
- R6: With LAT_F=3, LAT_G=1, FIFO_DEPTH=2, and with input always valid and output always ready, exactly 3 of every 4 cycles carry an output transfer in steady state.
- R7: A synchronous active-high reset clears every stage valid flag and empties the buffer. In the first cycle after reset, out_valid is low and in_ready is high, and no word that was held before the reset ever leaves.
- R8: Under random input gaps and random output backpressure, no word is lost or duplicated. The number of output transfers equals the number of accepted inputs once the block drains.
- R9: With out_ready held low and input always valid, the block accepts exactly min(LAT_F, LAT_G + FIFO_DEPTH) words and then holds in_ready low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input word offered |
| in_ready | output | 1 | Both branches can take a word this cycle |
| in_data | input | DATA_W | Input word |
| out_valid | output | 1 | Joined result available |
| out_ready | input | 1 | Downstream takes the result this cycle |
| out_data | output | DATA_W | Joined result H(F(x), G(x)) |

## Verification
A fixed table of words is sent back to back. The table covers zero, the sign boundary, all ones and alternating bit patterns. It shows whether the join keeps the pairing correct and wraps the addition properly. A single word sent into an idle block shows whether the latency is right. A long stall on the output shows whether the block holds its result, stops after the correct number of words and refuses later offers. A continuous stream shows whether the three-in-four transfer rate is met. A long run with random input gaps and random backpressure shows whether any word is lost, duplicated or paired with the wrong partner. A reset in the middle of a run shows whether every word held inside is discarded.

// File: rtl/fj_pkg.sv
package fj_pkg;

    typedef enum logic {
        BR_F = 1'b0,
        BR_G = 1'b1
    } branch_e;

    // The branch with fewer stages feeds the buffer; ties go to G.
    function automatic branch_e short_branch(input int lat_f, input int lat_g);
        return (lat_g <= lat_f) ? BR_G : BR_F;
    endfunction

    function automatic int max_int(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic int min_int(input int a, input int b);
        return (a < b) ? a : b;
    endfunction

    // Width of a counter that must hold the values 0..n.
    function automatic int cnt_width(input int n);
        return (n < 1) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/fj_delay_pipe.sv
module fj_delay_pipe #(
    parameter int W   = 16,
    parameter int LAT = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         up_valid,
    input  logic [W-1:0] up_data,
    output logic         up_ready,
    output logic         dn_valid,
    output logic [W-1:0] dn_data,
    input  logic         dn_ready
);
    logic [LAT-1:0] vld;
    logic [W-1:0]   dat  [LAT];
    logic [LAT:0]   room;
    logic [LAT-1:0] srcv;
    logic [W-1:0]   srcd [LAT];

    assign room[LAT] = dn_ready;

    for (genvar i = 0; i < LAT; i++) begin : g_stage
        // A stage can take a word if it is empty or its own word moves on.
        assign room[i] = !vld[i] || room[i+1];
        if (i == 0) begin : g_head
            assign srcv[i] = up_valid;
            assign srcd[i] = up_data;
        end else begin : g_body
            assign srcv[i] = vld[i-1];
            assign srcd[i] = dat[i-1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vld <= '0;
        end else begin
            for (int i = 0; i < LAT; i++) begin
                if (room[i]) vld[i] <= srcv[i];
            end
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < LAT; i++) begin
            if (room[i] && srcv[i]) dat[i] <= srcd[i];
        end
    end

    assign up_ready = room[0];
    assign dn_valid = vld[LAT-1];
    assign dn_data  = dat[LAT-1];

endmodule

// File: rtl/fj_fifo.sv
module fj_fifo #(
    parameter int W     = 16,
    parameter int DEPTH = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic [W-1:0] head_data,
    output logic         full,
    output logic         empty
);
    import fj_pkg::*;

    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = cnt_width(DEPTH);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] count;

    assign full      = (count == CW'(DEPTH));
    assign empty     = (count == '0);
    assign head_data = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            if (pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= push_data;
    end

    // R3: writer and reader respect the full and empty flags
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst) push |-> !full);
    p_no_underflow_r3: assert property (@(posedge clk) disable iff (rst) pop |-> !empty);

endmodule

// File: rtl/fj_join.sv
module fj_join #(
    parameter int W = 16
) (
    input  logic         f_valid,
    input  logic [W-1:0] f_data,
    input  logic         g_valid,
    input  logic [W-1:0] g_data,
    output logic         out_valid,
    output logic [W-1:0] out_data,
    input  logic         out_ready,
    output logic         fire
);
    assign out_valid = f_valid && g_valid;
    assign out_data  = f_data + g_data;
    assign fire      = out_valid && out_ready;
endmodule

// File: rtl/elastic_fork_join.sv
module elastic_fork_join #(
    parameter int DATA_W     = 16,
    parameter int LAT_F      = 3,
    parameter int LAT_G      = 1,
    parameter int FIFO_DEPTH = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DATA_W-1:0] out_data
);
    import fj_pkg::*;

    localparam branch_e SHORT     = short_branch(LAT_F, LAT_G);
    localparam int      LAT_LONG  = max_int(LAT_F, LAT_G);
    localparam int      LAT_SHORT = min_int(LAT_F, LAT_G);

    logic              l_up_ready, s_up_ready, fork_go;
    logic              l_valid, s_valid, s_room;
    logic [DATA_W-1:0] l_data, s_data, q_data;
    logic              q_push, q_full, q_empty, consume;
    logic              f_valid, g_valid;
    logic [DATA_W-1:0] f_data, g_data;

    // Fork: a word enters only when both branches can take it.
    assign in_ready = l_up_ready && s_up_ready;
    assign fork_go  = in_valid && in_ready;

    fj_delay_pipe #(.W(DATA_W), .LAT(LAT_LONG)) u_long (
        .clk      (clk),
        .rst      (rst),
        .up_valid (fork_go),
        .up_data  (in_data),
        .up_ready (l_up_ready),
        .dn_valid (l_valid),
        .dn_data  (l_data),
        .dn_ready (consume)
    );

    fj_delay_pipe #(.W(DATA_W), .LAT(LAT_SHORT)) u_short (
        .clk      (clk),
        .rst      (rst),
        .up_valid (fork_go),
        .up_data  (in_data),
        .up_ready (s_up_ready),
        .dn_valid (s_valid),
        .dn_data  (s_data),
        .dn_ready (s_room)
    );

    assign s_room = !q_full;
    assign q_push = s_valid && s_room;

    fj_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_skew (
        .clk       (clk),
        .rst       (rst),
        .push      (q_push),
        .push_data (s_data),
        .pop       (consume),
        .head_data (q_data),
        .full      (q_full),
        .empty     (q_empty)
    );

    // Route long-branch and buffered results to the F and G operands.
    if (SHORT == BR_G) begin : g_f_long
        assign f_valid = l_valid;
        assign f_data  = l_data;
        assign g_valid = !q_empty;
        assign g_data  = q_data;
    end else begin : g_g_long
        assign f_valid = !q_empty;
        assign f_data  = q_data;
        assign g_valid = l_valid;
        assign g_data  = l_data;
    end

    fj_join #(.W(DATA_W)) u_join (
        .f_valid   (f_valid),
        .f_data    (f_data),
        .g_valid   (g_valid),
        .g_data    (g_data),
        .out_valid (out_valid),
        .out_data  (out_data),
        .out_ready (out_ready),
        .fire      (consume)
    );

    // R4: a stalled result is held
    p_out_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> out_valid);
    p_data_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> $stable(out_data));
    // R7: the first cycle after reset shows an empty block
    p_reset_clear_r7: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!out_valid && in_ready));

endmodule

// File: tb/sim_elastic_fork_join.sv
module sim_elastic_fork_join;
    localparam int W  = 16;
    localparam int LF = 3;
    localparam int LG = 1;
    localparam int QD = 2;
    localparam int NV = 12;

    // {stimulus, expected result}
    localparam logic [2*W-1:0] VEC [NV] = '{
        {16'h0000, 16'h0000}, {16'h0001, 16'h0002}, {16'h7FFF, 16'hFFFE},
        {16'h8000, 16'h0000}, {16'hFFFF, 16'hFFFE}, {16'h1234, 16'h2468},
        {16'hA5A5, 16'h4B4A}, {16'h5A5A, 16'hB4B4}, {16'h00FF, 16'h01FE},
        {16'hFF00, 16'hFE00}, {16'h0F0F, 16'h1E1E}, {16'hC001, 16'h8002}
    };

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic         out_ready = 1'b0;
    logic [W-1:0] in_data = '0;
    logic         in_ready, out_valid;
    logic [W-1:0] out_data;

    always #4 clk = ~clk;

    elastic_fork_join #(.DATA_W(W), .LAT_F(LF), .LAT_G(LG), .FIFO_DEPTH(QD)) u0 (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_data   (in_data),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_data  (out_data)
    );

    int checks = 0, failures = 0, accepted = 0, fired = 0, cyc = 0;
    logic [W-1:0] expq [$];
    logic [W-1:0] gotq [$];

    function automatic logic [W-1:0] ref_h(input logic [W-1:0] x);
        return x + x;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp,
                         input string what);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    // Monitor: sample both handshakes in mid-cycle.
    always @(negedge clk) begin
        if (rst) begin
            expq.delete();
        end else begin
            if (in_valid && in_ready) begin
                expq.push_back(ref_h(in_data));
                accepted++;
            end
            if (out_valid && out_ready) begin
                fired++;
                gotq.push_back(out_data);
                if (expq.size() == 0) check("R1", 32'd1, 32'd0, "output with nothing pending");
                else check("R1", out_data, expq.pop_front(), "paired result");
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc >= 150000) begin
            failures++;
            $display("FAIL R1 watchdog actual=%0d expected=<150000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int a0, f0;
        logic [W-1:0] held;

        repeat (3) step();
        rst = 1'b0;
        step();
        check("R7", out_valid, 0, "out_valid after reset");
        check("R7", in_ready, 1, "in_ready after reset");

        // R5: latency of a lone word
        out_ready = 1'b1;
        in_valid  = 1'b1;
        in_data   = 16'h0123;
        step();
        in_valid = 1'b0;
        check("R5", out_valid, 0, "valid one edge after accept");
        step();
        check("R5", out_valid, 0, "valid two edges after accept");
        step();
        check("R5", out_valid, 1, "valid at LAT_F-1 edges");
        check("R5", out_data, 16'h0246, "data at LAT_F-1 edges");
        repeat (4) step();

        // R1: table walk, back to back
        gotq.delete();
        for (int k = 0; k < NV; k++) begin
            in_valid = 1'b1;
            in_data  = VEC[k][2*W-1:W];
            while (!in_ready) step();
            step();
        end
        in_valid = 1'b0;
        repeat (8) step();
        check("R1", gotq.size(), NV, "table output count");
        for (int k = 0; k < NV; k++) begin
            if (k < gotq.size()) check("R1", gotq[k], VEC[k][W-1:0], "table result");
        end

        // R9 / R4 / R2: output stalled, input always offered
        a0 = accepted;
        f0 = fired;
        out_ready = 1'b0;
        in_valid  = 1'b1;
        for (int k = 0; k < 10; k++) begin
            in_data = 16'h1000 + 16'(k);
            step();
        end
        check("R9", accepted - a0, 3, "words taken while stalled");
        check("R9", in_ready, 0, "in_ready while full");
        check("R4", out_valid, 1, "result held valid");
        held = out_data;
        step();
        step();
        check("R4", out_data, held, "result held stable");
        check("R4", out_data, 16'h2000, "held result is oldest word");
        in_valid  = 1'b0;
        out_ready = 1'b1;
        repeat (10) step();
        check("R2", fired - f0, 3, "refused offers never emerge");

        // R6: steady-state rate
        in_valid = 1'b1;
        for (int k = 0; k < 40; k++) begin
            in_data = 16'(k * 7);
            step();
        end
        f0 = fired;
        for (int k = 0; k < 400; k++) begin
            in_data = 16'(k * 13 + 5);
            step();
        end
        check("R6", fired - f0, 300, "transfers in 400 cycles");
        in_valid = 1'b0;
        repeat (10) step();

        // R8: random gaps and backpressure
        a0 = accepted;
        f0 = fired;
        for (int k = 0; k < 3000; k++) begin
            in_valid  = ($urandom_range(0, 3) != 0);
            in_data   = 16'($urandom);
            out_ready = ($urandom_range(0, 2) != 0);
            step();
        end
        in_valid  = 1'b0;
        out_ready = 1'b1;
        repeat (20) step();
        check("R8", expq.size(), 0, "pending words after drain");
        check("R8", fired - f0, accepted - a0, "outputs versus accepted");

        // R7: reset with words inside
        out_ready = 1'b0;
        in_valid  = 1'b1;
        in_data   = 16'h0777;
        repeat (3) step();
        rst      = 1'b1;
        in_valid = 1'b0;
        repeat (2) step();
        rst = 1'b0;
        step();
        check("R7", out_valid, 0, "out_valid after mid-run reset");
        check("R7", in_ready, 1, "in_ready after mid-run reset");
        f0 = fired;
        out_ready = 1'b1;
        repeat (6) step();
        check("R7", fired - f0, 0, "no word survives reset");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule